// File: doc/BRIEF.md
# DDR3 Command Decoder

This block sits behind the command/address input flops of a DDR3 device model or a protocol monitor. On each rising clock edge it samples the clock enable, chip select, the three active-low strobes (row strobe, column strobe, write enable), the bank bits and the address bus. From these it produces one command per cycle, together with the fields that command carries.

Each field is shaped by the command it belongs to. A10 means precharge-all during a precharge and auto-precharge during a read or write. A12 selects a 4-beat chop or an 8-beat burst for each read or write. During a mode register load, the bank bits pick the register and the address bits carry the opcode. Fields that do not belong to the current command are driven to zero. Every output is registered, so results appear one clock after sampling.

The design has no stored state beyond that output register. The command type is an enumeration with nine values: NOP=0, DESELECT=1, ACTIVATE=2, READ=3, WRITE=4, PRECHARGE=5, REFRESH=6, MODE_SET=7, ZQ_CAL=8. Each sampled cycle maps to exactly one of these in the next cycle, and there is no other transition.

Top module: `ddr3_cmd_decoder`

## Requirements
- R1: With clock enable HIGH and chip select LOW, {ras_n,cas_n,we_n} decode as 111=NOP(0), 011=ACTIVATE(2), 101=READ(3), 100=WRITE(4), 010=PRECHARGE(5), 001=REFRESH(6), 000=MODE_SET(7), 110=ZQ_CAL(8).
- R2: With clock enable HIGH and chip select HIGH, the command is DESELECT(1) whatever the strobes, bank and address carry, and every field is zero.
- R3: With clock enable LOW, the command is NOP(0) and every field is zero, whatever chip select and the other inputs carry.
- R4: ACTIVATE reports bank = ba and row = the full address bus.
- R5: READ and WRITE report bank = ba, col = addr[9:0] and auto_pre = addr[10].
- R6: bc4 is 1 for a READ or WRITE with addr[12]=0 (chop of 4), 0 for addr[12]=1 (burst of 8), and 0 for every other command.
- R7: PRECHARGE with addr[10]=0 reports pre_all=0 and bank = ba. With addr[10]=1 it reports pre_all=1 and bank = 0, ignoring ba.
- R8: MODE_SET reports mr_sel = ba[1:0] and mr_opcode = the full address bus.
- R9: Any field that does not belong to the current command (row, col, auto_pre, pre_all, mr_sel, mr_opcode, and bank for NOP/DESELECT/REFRESH/ZQ_CAL/MODE_SET) is zero.
- R10: Outputs change one clock after the inputs are sampled. While rst_n is LOW at a rising edge, the next outputs are NOP with all fields zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cke | input | 1 | Clock enable; LOW suppresses decoding |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 3 | Bank bits |
| addr | input | 16 | Address bus |
| cmd | output | 4 | Decoded command code |
| bank | output | 3 | Target bank |
| row | output | 16 | Row address for ACTIVATE |
| col | output | 10 | Column address for READ/WRITE |
| auto_pre | output | 1 | Auto-precharge for READ/WRITE |
| pre_all | output | 1 | All-bank precharge |
| bc4 | output | 1 | 4-beat chop for this access |
| mr_sel | output | 2 | Mode register index |
| mr_opcode | output | 16 | Mode register opcode |

## Verification
Two reuses of address bits can be active in the same sampled word. A READ or WRITE may carry A10 and A12 together, so auto-precharge and burst chop must both be reported from one cycle. A10 also serves as precharge-all during a precharge, so its meaning depends on the command. The bench provokes these cases with directed vectors that set both bits under each command. It also runs random words in which A10 and A12 take every combination under every strobe pattern, and under both levels of chip select and clock enable. Each result is compared one cycle later against a bench model. That model assigns A10 and A12 to auto_pre, pre_all or bc4 only for the commands named in R5 to R7, and expects zero everywhere else.

// File: rtl/ddr3_dec_pkg.sv
package ddr3_dec_pkg;
    localparam int CMD_W = 4;

    typedef enum logic [CMD_W-1:0] {
        CMD_NOP    = 4'd0,
        CMD_DESEL  = 4'd1,
        CMD_ACT    = 4'd2,
        CMD_RD     = 4'd3,
        CMD_WR     = 4'd4,
        CMD_PRE    = 4'd5,
        CMD_REF    = 4'd6,
        CMD_MRS    = 4'd7,
        CMD_ZQC    = 4'd8
    } cmd_e;
endpackage

// File: rtl/ddr3_cmd_class.sv
module ddr3_cmd_class
    import ddr3_dec_pkg::*;
(
    input  logic cke,
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);
    always_comb begin
        cmd = CMD_NOP;
        if (!cke) begin
            cmd = CMD_NOP;
        end else if (cs_n) begin
            cmd = CMD_DESEL;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b111: cmd = CMD_NOP;
                3'b011: cmd = CMD_ACT;
                3'b101: cmd = CMD_RD;
                3'b100: cmd = CMD_WR;
                3'b010: cmd = CMD_PRE;
                3'b001: cmd = CMD_REF;
                3'b000: cmd = CMD_MRS;
                3'b110: cmd = CMD_ZQC;
                default: cmd = CMD_NOP;
            endcase
        end
    end
endmodule

// File: rtl/ddr3_field_map.sv
module ddr3_field_map
    import ddr3_dec_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BANK_W = 3,
    parameter int COL_W  = 10,
    parameter int MR_W   = 2,
    parameter int AP_BIT = 10,
    parameter int BC_BIT = 12
) (
    input  cmd_e              cmd,
    input  logic [BANK_W-1:0] ba,
    input  logic [ADDR_W-1:0] addr,
    output logic [BANK_W-1:0] bank,
    output logic [ADDR_W-1:0] row,
    output logic [COL_W-1:0]  col,
    output logic              auto_pre,
    output logic              pre_all,
    output logic              bc4,
    output logic [MR_W-1:0]   mr_sel,
    output logic [ADDR_W-1:0] mr_opcode
);
    always_comb begin
        bank      = '0;
        row       = '0;
        col       = '0;
        auto_pre  = 1'b0;
        pre_all   = 1'b0;
        bc4       = 1'b0;
        mr_sel    = '0;
        mr_opcode = '0;
        unique case (cmd)
            CMD_ACT: begin
                bank = ba;
                row  = addr;
            end
            CMD_RD, CMD_WR: begin
                bank     = ba;
                col      = addr[COL_W-1:0];
                auto_pre = addr[AP_BIT];
                bc4      = ~addr[BC_BIT];
            end
            CMD_PRE: begin
                pre_all = addr[AP_BIT];
                bank    = addr[AP_BIT] ? '0 : ba;
            end
            CMD_MRS: begin
                mr_sel    = ba[MR_W-1:0];
                mr_opcode = addr;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ddr3_cmd_decoder.sv
module ddr3_cmd_decoder
    import ddr3_dec_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BANK_W = 3,
    parameter int COL_W  = 10,
    parameter int MR_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [BANK_W-1:0] ba,
    input  logic [ADDR_W-1:0] addr,
    output logic [CMD_W-1:0]  cmd,
    output logic [BANK_W-1:0] bank,
    output logic [ADDR_W-1:0] row,
    output logic [COL_W-1:0]  col,
    output logic              auto_pre,
    output logic              pre_all,
    output logic              bc4,
    output logic [MR_W-1:0]   mr_sel,
    output logic [ADDR_W-1:0] mr_opcode
);
    localparam int AP_BIT = 10;
    localparam int BC_BIT = 12;

    cmd_e              cmd_d;
    logic [BANK_W-1:0] bank_d;
    logic [ADDR_W-1:0] row_d;
    logic [COL_W-1:0]  col_d;
    logic              ap_d;
    logic              pall_d;
    logic              bc4_d;
    logic [MR_W-1:0]   mrs_d;
    logic [ADDR_W-1:0] op_d;

    ddr3_cmd_class u_class (
        .cke   (cke),
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd_d)
    );

    ddr3_field_map #(
        .ADDR_W (ADDR_W),
        .BANK_W (BANK_W),
        .COL_W  (COL_W),
        .MR_W   (MR_W),
        .AP_BIT (AP_BIT),
        .BC_BIT (BC_BIT)
    ) u_fields (
        .cmd       (cmd_d),
        .ba        (ba),
        .addr      (addr),
        .bank      (bank_d),
        .row       (row_d),
        .col       (col_d),
        .auto_pre  (ap_d),
        .pre_all   (pall_d),
        .bc4       (bc4_d),
        .mr_sel    (mrs_d),
        .mr_opcode (op_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd       <= CMD_NOP;
            bank      <= '0;
            row       <= '0;
            col       <= '0;
            auto_pre  <= 1'b0;
            pre_all   <= 1'b0;
            bc4       <= 1'b0;
            mr_sel    <= '0;
            mr_opcode <= '0;
        end else begin
            cmd       <= cmd_d;
            bank      <= bank_d;
            row       <= row_d;
            col       <= col_d;
            auto_pre  <= ap_d;
            pre_all   <= pall_d;
            bc4       <= bc4_d;
            mr_sel    <= mrs_d;
            mr_opcode <= op_d;
        end
    end
endmodule

// File: rtl/ddr3_cmd_decoder_chk.sv
module ddr3_cmd_decoder_chk
    import ddr3_dec_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             cke,
    input logic             cs_n,
    input logic             ras_n,
    input logic             cas_n,
    input logic             we_n,
    input logic [2:0]       ba,
    input logic [CMD_W-1:0] cmd,
    input logic [2:0]       bank,
    input logic             auto_pre,
    input logic             pre_all,
    input logic             bc4
);
    p_deselect_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && cs_n) |=> (cmd == CMD_DESEL && bank == 3'd0));

    p_cke_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |=> (cmd == CMD_NOP && !bc4 && !pre_all && !auto_pre));

    p_act_bank_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && !cs_n && !ras_n && cas_n && we_n) |=> (cmd == CMD_ACT && bank == $past(ba)));

    p_ap_scope_r5: assert property (@(posedge clk) disable iff (!rst_n)
        auto_pre |-> (cmd == CMD_RD || cmd == CMD_WR));

    p_bc_default_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != CMD_RD && cmd != CMD_WR) |-> !bc4);

    p_pre_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pre_all |-> (cmd == CMD_PRE && bank == 3'd0));

    p_reset_r10: assert property (@(posedge clk)
        !rst_n |=> (cmd == CMD_NOP && !bc4 && !pre_all));
endmodule

bind ddr3_cmd_decoder ddr3_cmd_decoder_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cke      (cke),
    .cs_n     (cs_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .ba       (ba),
    .cmd      (cmd),
    .bank     (bank),
    .auto_pre (auto_pre),
    .pre_all  (pre_all),
    .bc4      (bc4)
);

// File: tb/ddr3_cmd_decoder_tb.sv
module ddr3_cmd_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke = 1'b0, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [2:0]  ba = '0;
    logic [15:0] addr = '0;
    logic [3:0]  cmd;
    logic [2:0]  bank;
    logic [15:0] row;
    logic [9:0]  col;
    logic        auto_pre, pre_all, bc4;
    logic [1:0]  mr_sel;
    logic [15:0] mr_opcode;

    int vectors = 0;
    int fails = 0;
    bit done = 0;

    typedef struct packed {
        logic [3:0]  c;
        logic [2:0]  b;
        logic [15:0] r;
        logic [9:0]  cl;
        logic        ap, pa, bc;
        logic [1:0]  ms;
        logic [15:0] op;
    } exp_t;

    exp_t expv;

    always #5 clk = ~clk;

    ddr3_cmd_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .cmd(cmd),
        .bank(bank), .row(row), .col(col), .auto_pre(auto_pre),
        .pre_all(pre_all), .bc4(bc4), .mr_sel(mr_sel), .mr_opcode(mr_opcode)
    );

    function automatic exp_t model(logic k, logic s, logic r, logic c, logic w,
                                   logic [2:0] b, logic [15:0] a);
        exp_t e = '0;
        if (!k) e.c = 4'd0;
        else if (s) e.c = 4'd1;
        else begin
            case ({r, c, w})
                3'b111: e.c = 4'd0;
                3'b011: e.c = 4'd2;
                3'b101: e.c = 4'd3;
                3'b100: e.c = 4'd4;
                3'b010: e.c = 4'd5;
                3'b001: e.c = 4'd6;
                3'b000: e.c = 4'd7;
                default: e.c = 4'd8;
            endcase
        end
        if (e.c == 4'd2) begin e.b = b; e.r = a; end
        if (e.c == 4'd3 || e.c == 4'd4) begin
            e.b = b; e.cl = a[9:0]; e.ap = a[10]; e.bc = !a[12];
        end
        if (e.c == 4'd5) begin e.pa = a[10]; e.b = a[10] ? 3'd0 : b; end
        if (e.c == 4'd7) begin e.ms = b[1:0]; e.op = a; end
        return e;
    endfunction

    function automatic string tag_of(exp_t e);
        case (e.c)
            4'd1: return "R2";
            4'd2: return "R4";
            4'd3, 4'd4: return "R5/R6";
            4'd5: return "R7";
            4'd7: return "R8";
            default: return "R1/R3/R9";
        endcase
    endfunction

    task automatic check(exp_t e, string tag);
        exp_t got;
        got = {cmd, bank, row, col, auto_pre, pre_all, bc4, mr_sel, mr_opcode};
        vectors++;
        if (got !== e) begin
            fails++;
            $display("FAIL %s: actual cmd=%0d bank=%0d row=%h col=%h ap=%b pa=%b bc4=%b ms=%0d op=%h expected cmd=%0d bank=%0d row=%h col=%h ap=%b pa=%b bc4=%b ms=%0d op=%h",
                     tag, got.c, got.b, got.r, got.cl, got.ap, got.pa, got.bc, got.ms, got.op,
                     e.c, e.b, e.r, e.cl, e.ap, e.pa, e.bc, e.ms, e.op);
        end
    endtask

    // Drive one word at a falling edge; the rising edge registers it; the
    // following falling edge checks it (R10 one-cycle latency).
    task automatic apply(logic k, logic s, logic r, logic c, logic w,
                         logic [2:0] b, logic [15:0] a, string tag);
        @(negedge clk);
        cke = k; cs_n = s; ras_n = r; cas_n = c; we_n = w; ba = b; addr = a;
        expv = model(k, s, r, c, w, b, a);
        @(negedge clk);
        check(expv, (tag == "") ? tag_of(expv) : tag);
    endtask

    initial begin : watchdog
        #1500000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin : stim
        logic [2:0] pat;
        void'($urandom(32'h0dd3c0de));
        // R10: reset state, with busy inputs that must not leak through
        cke = 1'b1; cs_n = 1'b0; ras_n = 1'b0; cas_n = 1'b1; we_n = 1'b1; addr = 16'hFFFF; ba = 3'd7;
        repeat (3) @(negedge clk);
        check('0, "R10");
        @(negedge clk);
        rst_n = 1'b1;
        // R1: every strobe pattern with CS low
        for (int i = 0; i < 8; i++) begin
            pat = 3'(i);
            apply(1'b1, 1'b0, pat[2], pat[1], pat[0], 3'd5, 16'h1234, "R1");
        end
        // R2: chip select high masks a read
        apply(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 3'd3, 16'hFFFF, "R2");
        // R3: clock enable low overrides CS high and an MRS pattern
        apply(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd2, 16'hABCD, "R3");
        apply(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd6, 16'h5555, "R3");
        // R4: activate with the top row bit set
        apply(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 3'd7, 16'h8001, "R4");
        // R5 and R6: A10 and A12 together in one read / write
        apply(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 3'd1, 16'h1400 | 16'h3FF, "R5");
        apply(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 3'd4, 16'h0000, "R6");
        apply(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 3'd4, 16'h0400, "R6");
        // R6: A12 on a non-access command keeps burst default
        apply(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 3'd2, 16'h0000, "R6");
        // R7: precharge single bank and all banks
        apply(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 3'd6, 16'h0000, "R7");
        apply(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 3'd6, 16'h0400, "R7");
        // R8: mode register set with BA2 set and full opcode
        apply(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd7, 16'hC3A5, "R8");
        // R9: refresh and ZQ carry no fields
        apply(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 3'd5, 16'hFFFF, "R9");
        apply(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 3'd5, 16'hFFFF, "R9");
        // Random mix
        for (int n = 0; n < 600; n++) begin
            logic [31:0] rv;
            rv = $urandom;
            apply(rv[0] | rv[1], rv[2] & rv[3], rv[4], rv[5], rv[6], rv[9:7],
                  16'($urandom), "");
        end
        // R10: reset mid-stream returns to NOP
        @(negedge clk);
        rst_n = 1'b0; cke = 1'b1; cs_n = 1'b0; ras_n = 1'b0; cas_n = 1'b1; we_n = 1'b1;
        @(negedge clk);
        check('0, "R10");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule